// File: doc/BRIEF.md
# Microprogram Sequencer with Subroutine Register

This block chooses the next control-memory address in a microprogrammed control unit. It holds a 7-bit control address and a single-entry return register. On every enabled clock edge it reads the current microinstruction's branch-kind, test-select and target-address fields. It also reads three status inputs and the four opcode bits of the instruction word. From these it loads the control address from one of four sources: the incremented address, the target field, the return register, or an address formed from the opcode.

A call with a true test saves the incremented address in the return register. A later return jumps back to that saved address. Map mode sends each opcode to its own four-word routine, which starts at opcode times four. The control memory, the decoding of the microoperation fields and the datapath all sit outside the block. The address output feeds the external control memory.

The source choice is the block's state. Its four named states are SRC_INCR, SRC_TARGET, SRC_RETURN and SRC_MAP, and the next-state logic picks one of them on each enabled edge. The transitions are:
- jump-taken (jump or call with a true test) goes to SRC_TARGET;
- jump-not-taken goes to SRC_INCR;
- return goes to SRC_RETURN;
- map goes to SRC_MAP.

A reset loads the start address.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous, active-high reset loads the control address with 64 (binary 1000000) and clears the return register to 0.
- R2: The test bit is chosen by `test_sel`: 00 gives constant 1, 01 gives `ir_indirect`, 10 gives `ac_sign`, 11 gives `ac_zero`.
- R3: With `br_kind` 00 (jump), the control address loads `target` when the test bit is 1 and loads its own value plus one when the test bit is 0.
- R4: With `br_kind` 01 (call) and a true test, the control address loads `target` and, on the same edge, the return register loads the old control address plus one.
- R5: With `br_kind` 10 (return), the control address loads the return register, whatever the test bit is.
- R6: With `br_kind` 11 (map), control address bits 5..2 load `opcode` bits 3..0, and bits 6, 1 and 0 become 0.
- R7: Incrementing the control address from 127 gives 0.
- R8: While `adv_en` is low, the control address and the return register keep their values.
- R9: A call with a false test increments the control address and leaves the return register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance enable; when low, all state holds |
| test_sel | input | 2 | Test-bit select field of the microinstruction |
| br_kind | input | 2 | Branch-kind field: 00 jump, 01 call, 10 return, 11 map |
| target | input | 7 | Target address field of the microinstruction |
| ir_indirect | input | 1 | Indirect bit of the instruction word |
| opcode | input | 4 | Opcode bits of the instruction word |
| ac_sign | input | 1 | Accumulator sign bit |
| ac_zero | input | 1 | Accumulator-is-zero flag |
| car | output | 7 | Control address to the control memory |

## Verification
The return register has no port of its own, so it can only be observed through a later return. The hardest cases to reach are therefore a false-test call and a held call, each of which must leave the saved address alone. To reach them, the stimulus first makes a true call, so the register holds a known value. It then issues the false or held call and finishes with a return, whose target shows whether the register changed. The wrap from 127 to 0 is reached by jumping straight to 127 and then issuing a jump whose test is false.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Branch-kind field of the microinstruction
    typedef enum logic [1:0] {
        BK_JUMP   = 2'b00,
        BK_CALL   = 2'b01,
        BK_RETURN = 2'b10,
        BK_MAP    = 2'b11
    } br_kind_e;

    // Test-bit select field
    typedef enum logic [1:0] {
        TS_ALWAYS   = 2'b00,
        TS_INDIRECT = 2'b01,
        TS_SIGN     = 2'b10,
        TS_ZERO     = 2'b11
    } test_sel_e;

    // Next-address source (the sequencer's state)
    typedef enum logic [1:0] {
        SRC_INCR   = 2'b00,
        SRC_TARGET = 2'b01,
        SRC_RETURN = 2'b10,
        SRC_MAP    = 2'b11
    } src_e;

endpackage

// File: rtl/useq_test_mux.sv
module useq_test_mux
    import useq_pkg::*;
(
    input  logic [1:0] test_sel,
    input  logic       ir_indirect,
    input  logic       ac_sign,
    input  logic       ac_zero,
    output logic       test_bit
);

    always_comb begin
        unique case (test_sel_e'(test_sel))
            TS_ALWAYS:   test_bit = 1'b1;
            TS_INDIRECT: test_bit = ir_indirect;
            TS_SIGN:     test_bit = ac_sign;
            TS_ZERO:     test_bit = ac_zero;
        endcase
    end

endmodule

// File: rtl/useq_src_select.sv
module useq_src_select
    import useq_pkg::*;
(
    input  logic [1:0] br_kind,
    input  logic       test_bit,
    output src_e       src,
    output logic       save_ret
);

    // Next-state selection: picks the source state for this edge
    always_comb begin
        unique case (br_kind_e'(br_kind))
            BK_JUMP:   src = test_bit ? SRC_TARGET : SRC_INCR;
            BK_CALL:   src = test_bit ? SRC_TARGET : SRC_INCR;
            BK_RETURN: src = SRC_RETURN;
            BK_MAP:    src = SRC_MAP;
        endcase
    end

    // Output process: return-register load strobe
    always_comb begin
        unique case (br_kind_e'(br_kind))
            BK_CALL: save_ret = test_bit;
            default: save_ret = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int AW      = 7,
    parameter int OPW     = 4,
    parameter int MAP_LSB = 2
) (
    input  logic [AW-1:0]  car,
    input  logic [AW-1:0]  sbr,
    input  logic [AW-1:0]  target,
    input  logic [OPW-1:0] opcode,
    input  src_e           src,
    output logic [AW-1:0]  incr,
    output logic [AW-1:0]  nxt
);

    localparam int MAP_MSB = MAP_LSB + OPW - 1;

    logic [AW-1:0] mapped;

    assign incr = car + AW'(1);

    // Opcode bits land at MAP_MSB..MAP_LSB, all other bits zero
    generate
        for (genvar i = 0; i < AW; i++) begin : g_map
            if (i >= MAP_LSB && i <= MAP_MSB) begin : g_op
                assign mapped[i] = opcode[i-MAP_LSB];
            end else begin : g_zero
                assign mapped[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_INCR:   nxt = incr;
            SRC_TARGET: nxt = target;
            SRC_RETURN: nxt = sbr;
            SRC_MAP:    nxt = mapped;
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int AW         = 7,
    parameter int OPW        = 4,
    parameter int MAP_LSB    = 2,
    parameter int START_ADDR = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adv_en,
    input  logic [1:0]     test_sel,
    input  logic [1:0]     br_kind,
    input  logic [AW-1:0]  target,
    input  logic           ir_indirect,
    input  logic [OPW-1:0] opcode,
    input  logic           ac_sign,
    input  logic           ac_zero,
    output logic [AW-1:0]  car
);

    localparam logic [AW-1:0] START_VEC = AW'(START_ADDR);

    logic          test_bit;
    logic          save_ret;
    src_e          src;
    logic [AW-1:0] sbr;
    logic [AW-1:0] incr;
    logic [AW-1:0] nxt;

    useq_test_mux u_test (
        .test_sel    (test_sel),
        .ir_indirect (ir_indirect),
        .ac_sign     (ac_sign),
        .ac_zero     (ac_zero),
        .test_bit    (test_bit)
    );

    useq_src_select u_sel (
        .br_kind  (br_kind),
        .test_bit (test_bit),
        .src      (src),
        .save_ret (save_ret)
    );

    useq_next_addr #(
        .AW      (AW),
        .OPW     (OPW),
        .MAP_LSB (MAP_LSB)
    ) u_addr (
        .car    (car),
        .sbr    (sbr),
        .target (target),
        .opcode (opcode),
        .src    (src),
        .incr   (incr),
        .nxt    (nxt)
    );

    // State register: control address and return register
    always_ff @(posedge clk) begin
        if (rst) begin
            car <= START_VEC;
            sbr <= '0;
        end else if (adv_en) begin
            car <= nxt;
            if (save_ret) begin
                sbr <= incr;
            end
        end
    end

    p_reset_start_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> car == START_VEC);

    p_jump_taken_r3: assert property (@(posedge clk) disable iff (rst)
        adv_en && br_kind == BK_JUMP && test_bit |=> car == $past(target));

    p_call_save_r4: assert property (@(posedge clk) disable iff (rst)
        adv_en && br_kind == BK_CALL && test_bit
        |=> car == $past(target) && sbr == AW'($past(car) + AW'(1)));

    p_return_r5: assert property (@(posedge clk) disable iff (rst)
        adv_en && br_kind == BK_RETURN |=> car == $past(sbr));

    p_map_zero_r6: assert property (@(posedge clk) disable iff (rst)
        adv_en && br_kind == BK_MAP
        |=> car[AW-1] == 1'b0 && car[1:0] == 2'b00);

    p_not_taken_r7: assert property (@(posedge clk) disable iff (rst)
        adv_en && !br_kind[1] && !test_bit
        |=> car == AW'($past(car) + AW'(1)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> $stable(car) && $stable(sbr));

    p_call_false_r9: assert property (@(posedge clk) disable iff (rst)
        adv_en && br_kind == BK_CALL && !test_bit |=> $stable(sbr));

endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_en = 1'b0;
    logic [1:0] test_sel = 2'b00;
    logic [1:0] br_kind = 2'b00;
    logic [6:0] target = '0;
    logic       ir_indirect = 1'b0;
    logic [3:0] opcode = '0;
    logic       ac_sign = 1'b0;
    logic       ac_zero = 1'b0;
    logic [6:0] car;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    useq_sequencer u_dut (
        .clk         (clk),
        .rst         (rst),
        .adv_en      (adv_en),
        .test_sel    (test_sel),
        .br_kind     (br_kind),
        .target      (target),
        .ir_indirect (ir_indirect),
        .opcode      (opcode),
        .ac_sign     (ac_sign),
        .ac_zero     (ac_zero),
        .car         (car)
    );

    task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: car=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Drive fields at negedge, let one rising edge pass, sample 1 ns later
    task automatic step(input logic en, input logic [1:0] ts, input logic [1:0] bk,
                        input logic [6:0] ad);
        @(negedge clk);
        adv_en = en; test_sel = ts; br_kind = bk; target = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 start address", car, 7'd64);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 2'b00, 2'b10, 7'd0);
        chk("R1 return register cleared", car, 7'd0);
    endtask

    task automatic t_cond();
        step(1'b1, 2'b00, 2'b00, 7'd20);
        chk("R2 R3 always jump", car, 7'd20);
        ir_indirect = 1'b1;
        step(1'b1, 2'b01, 2'b00, 7'd30);
        chk("R2 indirect true", car, 7'd30);
        ir_indirect = 1'b0;
        step(1'b1, 2'b01, 2'b00, 7'd50);
        chk("R3 indirect false increments", car, 7'd31);
        ac_sign = 1'b1;
        step(1'b1, 2'b10, 2'b00, 7'd5);
        chk("R2 sign true", car, 7'd5);
        ac_sign = 1'b0;
        step(1'b1, 2'b10, 2'b00, 7'd90);
        chk("R2 sign false", car, 7'd6);
        ac_zero = 1'b1;
        step(1'b1, 2'b11, 2'b00, 7'd100);
        chk("R2 zero true", car, 7'd100);
        ac_zero = 1'b0;
        step(1'b1, 2'b11, 2'b00, 7'd3);
        chk("R2 zero false", car, 7'd101);
    endtask

    task automatic t_call();
        step(1'b1, 2'b00, 2'b01, 7'd67);
        chk("R4 call target", car, 7'd67);
        step(1'b1, 2'b00, 2'b10, 7'd0);
        chk("R4 R5 return to caller+1", car, 7'd102);
        ir_indirect = 1'b0;
        step(1'b1, 2'b01, 2'b01, 7'd10);
        chk("R9 false call increments", car, 7'd103);
        step(1'b1, 2'b00, 2'b10, 7'd0);
        chk("R9 false call kept return register", car, 7'd102);
        step(1'b1, 2'b01, 2'b10, 7'd55);
        chk("R5 return ignores false test", car, 7'd102);
    endtask

    task automatic t_map();
        opcode = 4'b1011;
        step(1'b1, 2'b00, 2'b11, 7'd127);
        chk("R6 map 1011", car, 7'd44);
        opcode = 4'b1111;
        step(1'b1, 2'b01, 2'b11, 7'd127);
        chk("R6 map 1111", car, 7'd60);
        opcode = 4'b0000;
        step(1'b1, 2'b00, 2'b11, 7'd127);
        chk("R6 map 0000", car, 7'd0);
    endtask

    task automatic t_wrap();
        step(1'b1, 2'b00, 2'b00, 7'd127);
        chk("R3 jump to 127", car, 7'd127);
        ir_indirect = 1'b0;
        step(1'b1, 2'b01, 2'b00, 7'd40);
        chk("R7 jump not taken wraps", car, 7'd0);
        step(1'b1, 2'b00, 2'b00, 7'd127);
        step(1'b1, 2'b01, 2'b01, 7'd40);
        chk("R7 R9 false call wraps", car, 7'd0);
    endtask

    task automatic t_hold();
        step(1'b1, 2'b00, 2'b01, 7'd90);
        chk("R4 call from 0", car, 7'd90);
        step(1'b0, 2'b00, 2'b01, 7'd10);
        chk("R8 held call", car, 7'd90);
        step(1'b0, 2'b00, 2'b11, 7'd10);
        chk("R8 held map", car, 7'd90);
        step(1'b1, 2'b00, 2'b10, 7'd0);
        chk("R8 return register held", car, 7'd1);
    endtask

    initial begin
        t_reset();
        t_cond();
        t_call();
        t_map();
        t_wrap();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: car=%0d expected=finish", car);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule